// File: doc/BRIEF.md
# Read-Sequence Store/Recall Detector

This block sits beside a small SRAM and watches the address presented with every chip-enable-qualified access. A nonvolatile store or a nonvolatile recall is started without any extra pins: software issues six reads to a fixed list of addresses, back to back. Both lists share their first five addresses and differ only in the last one. Any other access inside the run cancels it.

When the sixth read matches, the block raises a one-cycle start pulse toward the nonvolatile controller. It then holds a chip-disable output high, which blocks normal accesses, until the controller signals completion with a one-cycle done pulse. Strobes are counted on their rising edge, so a strobe held over several clocks is one access. While the chip is disabled, every access is ignored by the detector.

Top module: `seqdet_top`

## Requirements
- R1: During and immediately after a synchronous active-high reset, `store_start`, `recall_start` and `chip_off` are low.
- R2: Rising read strobes at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, with no other access between them, make `store_start` high for exactly one cycle: the cycle after the clock edge that samples the sixth strobe. `recall_start` stays low.
- R3: The same first five reads followed by a read at 0x0C63 make `recall_start` high for exactly one cycle, with the same timing as R2. `store_start` stays low.
- R4: A read at any address other than the expected next one abandons the run, and no start pulse follows the rest of that run.
- R5: A write abandons the run, including a write at the address that was expected next. Writes never advance the run.
- R6: A read that abandons the run and is itself at 0x0000 counts as the first read of a new run.
- R7: An access is counted once, on the rising edge of its strobe. A strobe held high over several clocks, even while the address changes, adds only one access.
- R8: `chip_off` rises together with a start pulse and stays high until the cycle after `nv_done` is seen high. It is low again in the following cycle.
- R9: While `chip_off` is high, reads and writes neither advance nor abandon the run, and no start pulse is issued. The run restarts from its first step when `chip_off` falls.
- R10: `store_start` and `recall_start` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Address of the current access |
| rd_stb | input | 1 | Chip-enabled read strobe |
| wr_stb | input | 1 | Chip-enabled write strobe |
| nv_done | input | 1 | One-cycle pulse when the store or recall has finished |
| store_start | output | 1 | One-cycle request to begin a nonvolatile store |
| recall_start | output | 1 | One-cycle request to begin a nonvolatile recall |
| chip_off | output | 1 | High while normal SRAM access is blocked |

## Verification
The bench builds the block with its default parameters: a 13-bit address and a six-step run. The full address list and both tail addresses are therefore reachable, along with every abort point. It drives reads that stop at intermediate steps, a write at exactly the expected address, and a run restarted by a stray 0x0000. It also holds a strobe high while the address changes, and sends a nearly complete run while the chip is disabled, to show that nothing leaks across the disabled window.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int ADDR_W  = 13;
    localparam int SEQ_LEN = 6;
    localparam int STEP_W  = $clog2(SEQ_LEN);
    localparam int LAST    = SEQ_LEN - 1;

    localparam logic [ADDR_W-1:0] TAIL_STORE  = 13'h0F0F;
    localparam logic [ADDR_W-1:0] TAIL_RECALL = 13'h0C63;
    localparam logic [ADDR_W-1:0] RESTART_ADR = 13'h0000;

    typedef enum logic {
        MODE_WATCH = 1'b0,
        MODE_HOLD  = 1'b1
    } seq_mode_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_ev_t;

    typedef struct packed {
        logic step_ok;
        logic tail_store;
        logic tail_recall;
        logic restart;
    } match_t;

    // Address expected at a given step of the shared prefix.
    function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
        case (idx)
            0:       return 13'h0000;
            1:       return 13'h1555;
            2:       return 13'h0AAA;
            3:       return 13'h1FFF;
            4:       return 13'h10F0;
            default: return 13'h0000;
        endcase
    endfunction

endpackage

// File: rtl/seqdet_edge.sv
module seqdet_edge
    import seqdet_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_stb,
    input  logic    wr_stb,
    output acc_ev_t ev
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] prev;
    logic [NSIG-1:0] rise;

    assign raw = {rd_stb, wr_stb};

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= raw;
    end

    for (genvar i = 0; i < NSIG; i++) begin : g_rise
        assign rise[i] = raw[i] & ~prev[i];
    end

    assign ev.rd = rise[1];
    assign ev.wr = rise[0];

endmodule

// File: rtl/seqdet_match.sv
module seqdet_match
    import seqdet_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [STEP_W-1:0] step,
    output match_t            m
);
    localparam int SLOTS = 1 << STEP_W;

    logic [SLOTS-1:0] hits;

    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        if (i < LAST) begin : g_live
            assign hits[i] = (addr == prefix_addr(i));
        end else begin : g_pad
            assign hits[i] = 1'b0;
        end
    end

    assign m.step_ok     = hits[step];
    assign m.tail_store  = (addr == TAIL_STORE);
    assign m.tail_recall = (addr == TAIL_RECALL);
    assign m.restart     = (addr == RESTART_ADR);

endmodule

// File: rtl/seqdet_fsm.sv
module seqdet_fsm
    import seqdet_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  acc_ev_t ev,
    input  match_t  m,
    input  logic    nv_done,
    output logic [STEP_W-1:0] step,
    output logic    store_start,
    output logic    recall_start,
    output logic    chip_off
);
    seq_mode_e mode;
    logic [STEP_W-1:0] step_fail;

    assign step_fail = m.restart ? STEP_W'(1) : '0;
    assign chip_off  = (mode == MODE_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= MODE_WATCH;
            step         <= '0;
            store_start  <= 1'b0;
            recall_start <= 1'b0;
        end else begin
            store_start  <= 1'b0;
            recall_start <= 1'b0;
            case (mode)
                MODE_WATCH: begin
                    if (ev.wr) begin
                        step <= '0;
                    end else if (ev.rd) begin
                        if (step == STEP_W'(LAST)) begin
                            if (m.tail_store) begin
                                store_start <= 1'b1;
                                mode        <= MODE_HOLD;
                                step        <= '0;
                            end else if (m.tail_recall) begin
                                recall_start <= 1'b1;
                                mode         <= MODE_HOLD;
                                step         <= '0;
                            end else begin
                                step <= step_fail;
                            end
                        end else if (m.step_ok) begin
                            step <= step + STEP_W'(1);
                        end else begin
                            step <= step_fail;
                        end
                    end
                end
                MODE_HOLD: begin
                    if (nv_done) mode <= MODE_WATCH;
                end
                default: mode <= MODE_WATCH;
            endcase
        end
    end

endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
    import seqdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              nv_done,
    output logic              store_start,
    output logic              recall_start,
    output logic              chip_off
);
    acc_ev_t           ev;
    match_t            m;
    logic [STEP_W-1:0] step;

    seqdet_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .ev     (ev)
    );

    seqdet_match u_match (
        .addr (addr),
        .step (step),
        .m    (m)
    );

    seqdet_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .m            (m),
        .nv_done      (nv_done),
        .step         (step),
        .store_start  (store_start),
        .recall_start (recall_start),
        .chip_off     (chip_off)
    );

endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker (
    input logic clk,
    input logic rst,
    input logic nv_done,
    input logic store_start,
    input logic recall_start,
    input logic chip_off
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!store_start && !recall_start && !chip_off));

    a_r2_store_single: assert property (@(posedge clk) disable iff (rst)
        store_start |=> !store_start);

    a_r3_recall_single: assert property (@(posedge clk) disable iff (rst)
        recall_start |=> !recall_start);

    a_r8_off_with_start: assert property (@(posedge clk) disable iff (rst)
        (store_start || recall_start) |-> chip_off);

    a_r8_off_holds: assert property (@(posedge clk) disable iff (rst)
        (chip_off && !nv_done) |=> chip_off);

    a_r8_off_release: assert property (@(posedge clk) disable iff (rst)
        (chip_off && nv_done) |=> !chip_off);

    a_r9_no_start_in_hold: assert property (@(posedge clk) disable iff (rst)
        chip_off |=> (!store_start && !recall_start));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({store_start, recall_start}) <= 1);

endmodule

bind seqdet_top seqdet_checker u_checker (
    .clk          (clk),
    .rst          (rst),
    .nv_done      (nv_done),
    .store_start  (store_start),
    .recall_start (recall_start),
    .chip_off     (chip_off)
);

// File: tb/seqdet_top_bench.sv
module seqdet_top_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic        nv_done = 1'b0;
    logic        store_start, recall_start, chip_off;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqdet_top u_seqdet_top (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .nv_done      (nv_done),
        .store_start  (store_start),
        .recall_start (recall_start),
        .chip_off     (chip_off)
    );

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {store,recall,off} got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {store_start, recall_start, chip_off};
    endfunction

    // One read: strobe high across one edge, back at the next negedge.
    task automatic rd(input logic [12:0] a);
        @(negedge clk); addr = a; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic wr(input logic [12:0] a);
        @(negedge clk); addr = a; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic prefix();
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0);
    endtask

    task automatic finish_nv(input string req);
        @(negedge clk); nv_done = 1'b1;
        @(negedge clk); nv_done = 1'b0;
        check(req, outs(), 3'b000);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), 3'b000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", outs(), 3'b000);
    endtask

    task automatic t_store();
        prefix();
        check("R2 no early start", outs(), 3'b000);
        rd(13'h0F0F);
        check("R2 store pulse", outs(), 3'b101);
        @(negedge clk);
        check("R2 pulse one cycle", outs(), 3'b001);
        repeat (4) @(negedge clk);
        check("R8 off held", outs(), 3'b001);
        finish_nv("R8 released");
    endtask

    task automatic t_recall();
        prefix();
        rd(13'h0C63);
        check("R3 recall pulse", outs(), 3'b011);
        @(negedge clk);
        check("R3 pulse one cycle", outs(), 3'b001);
        finish_nv("R8 released after recall");
    endtask

    task automatic t_abort_read();
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA);
        rd(13'h0123);
        rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R4 stray read aborts", outs(), 3'b000);
        prefix();
        rd(13'h0AAA);
        check("R4 wrong tail", outs(), 3'b000);
    endtask

    task automatic t_write();
        rd(13'h0000); rd(13'h1555);
        wr(13'h0AAA);
        rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R5 write at expected addr aborts", outs(), 3'b000);
        prefix();
        wr(13'h0F0F);
        check("R5 write at tail no start", outs(), 3'b000);
        rd(13'h0F0F);
        check("R5 run gone after write", outs(), 3'b000);
    endtask

    task automatic t_restart();
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA);
        rd(13'h0000);
        rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0);
        rd(13'h0F0F);
        check("R6 restart at 0x0000", outs(), 3'b101);
        finish_nv("R6 release");
    endtask

    task automatic t_held();
        @(negedge clk); addr = 13'h0000; rd_stb = 1'b1;
        repeat (2) @(negedge clk);
        addr = 13'h1555;
        repeat (2) @(negedge clk);
        rd_stb = 1'b0;
        rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R7 held strobe counted once", outs(), 3'b000);
        @(negedge clk); addr = 13'h0000; rd_stb = 1'b1;
        repeat (3) @(negedge clk);
        rd_stb = 1'b0;
        rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R7 long strobe still one read", outs(), 3'b101);
        finish_nv("R7 release");
    endtask

    task automatic t_hold_ignore();
        prefix();
        rd(13'h0F0F);
        check("R9 enter hold", outs(), 3'b101);
        prefix();
        wr(13'h0000);
        rd(13'h0C63);
        check("R9 no start while off", outs(), 3'b001);
        finish_nv("R9 release");
        rd(13'h0F0F);
        check("R9 run restarts after hold", outs(), 3'b000);
        prefix();
        rd(13'h0C63);
        check("R9 fresh recall after hold", outs(), 3'b011);
        @(negedge clk);
        nv_done = 1'b1;
        @(negedge clk);
        nv_done = 1'b0;
        check("R10 quiet after done", outs(), 3'b000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_store();
        t_recall();
        t_abort_read();
        t_write();
        t_restart();
        t_held();
        t_hold_ignore();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule